// File: doc/BRIEF.md
# Low-Power Escape Command Sender

This block drives one serial lane's low-power wire pair to send a single 8-bit escape command. A controller presents the command code with a one-cycle valid strobe and a bit-period setting. The block first leaves the stop state through a fixed four-state entry handshake. It then sends the eight command bits, each as a single-ended pulse in which exactly one wire is high. An all-low spacer follows every bit. A state with both wires equal never carries a bit value.

When the ultra-low-power request code is sent, the lane is parked with both wires low. The busy flag stays high until a wake request arrives. On wake, the lane drives a mark state for a programmable number of cycles and then returns to stop. Any other command ends with a single mark period followed by stop. The output is a two-bit line code: bit 1 is the P wire and bit 0 is the N wire.

Top module: `lp_esc_tx`

## Requirements
- R1: After reset, and whenever busy is low, the line code is 11 (stop state).
- R2: With busy low, a high cmd_valid at a clock edge accepts cmd_code and period_cfg. From the next cycle busy is high and the line code is not 11.
- R3: After acceptance the lane drives 10, 00, 01, 00 in that order, each held for one bit period.
- R4: The command bits then follow from bit 7 down to bit 0. A 1 is driven as 10 and a 0 as 01, and each bit is followed by one bit period of 00.
- R5: One bit period lasts max(period_cfg, MIN_PERIOD) clock cycles, with both values captured at acceptance. The default MIN_PERIOD of 10 gives at least 100 ns on a 100 MHz clock.
- R6: If the accepted code equals ULPS_CODE (default 8'h1E, bit pattern 00011110), the lane holds 00 after the last spacer and busy stays high until wake_req is seen high.
- R7: After wake_req is sampled in the parked state, the lane drives 10 for max(wake_cfg, 1) cycles. The line code then becomes 11 and busy falls in the same cycle. wake_cfg is captured at acceptance.
- R8: For any other code, the lane drives 10 for one bit period after the last spacer. The line code then becomes 11 and busy falls.
- R9: cmd_valid while busy is high is ignored, and the sequence in progress continues unchanged.
- R10: wake_req outside the parked state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_code | input | 8 | Escape command code |
| period_cfg | input | PERIOD_W | Bit period in clock cycles |
| wake_cfg | input | WAKE_W | Wake mark length in cycles |
| wake_req | input | 1 | Leave the parked state |
| lane_lp | output | 2 | Line code {P, N} |
| busy | output | 1 | Sequence in progress |

## Verification
A wrong step index or a lost command bit shows up on lane_lp within one bit period. The bench compares the line code in every single cycle, so a misplaced or shortened state is caught on the first cycle where it is wrong. A timer that ends a period early or late shifts every later state, and the mismatch appears within a single cycle. A wrong decision at the end of the sequence appears at the first cycle after the last spacer: parking when the lane should exit, or the reverse. If a wake request is honoured outside the parked state, or busy drops early, the stop code 11 appears while the bench expects a non-stop code.

// File: rtl/lp_esc_pkg.sv
package lp_esc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_EXIT,
        ST_PARK,
        ST_WAKE
    } esc_state_e;

    localparam logic [1:0] LP_11 = 2'b11;
    localparam logic [1:0] LP_10 = 2'b10;
    localparam logic [1:0] LP_01 = 2'b01;
    localparam logic [1:0] LP_00 = 2'b00;

    localparam int ENTRY_STEPS = 4;

endpackage

// File: rtl/lp_esc_timer.sv
module lp_esc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         done
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = run && (tmr_q.cnt == limit - W'(1));
        if (restart) begin
            tmr_d.cnt = '0;
        end else if (run) begin
            tmr_d.cnt = done ? '0 : tmr_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // A running count stays inside the programmed window (bit period length)
    assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && limit != '0) |-> (tmr_q.cnt < limit));

endmodule

// File: rtl/lp_esc_encoder.sv
module lp_esc_encoder
    import lp_esc_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int STEP_W = 5
) (
    input  esc_state_e        st,
    input  logic [STEP_W-1:0] step,
    input  logic [CMD_W-1:0]  cmd,
    output logic [1:0]        code
);

    logic [STEP_W-1:0] rel;
    logic [STEP_W-1:0] bit_idx;
    logic              bit_val;

    always_comb begin
        rel     = step - STEP_W'(ENTRY_STEPS);
        bit_idx = STEP_W'(CMD_W - 1) - (rel >> 1);
        bit_val = cmd[bit_idx[$clog2(CMD_W)-1:0]];
        code    = LP_11;
        unique case (st)
            ST_IDLE: code = LP_11;
            ST_SEND: begin
                if (step < STEP_W'(ENTRY_STEPS)) begin
                    unique case (step[1:0])
                        2'd0: code = LP_10;
                        2'd1: code = LP_00;
                        2'd2: code = LP_01;
                        default: code = LP_00;
                    endcase
                end else if (rel[0]) begin
                    code = LP_00;
                end else begin
                    code = bit_val ? LP_10 : LP_01;
                end
            end
            ST_EXIT: code = LP_10;
            ST_PARK: code = LP_00;
            ST_WAKE: code = LP_10;
            default: code = LP_11;
        endcase
    end

endmodule

// File: rtl/lp_esc_tx.sv
module lp_esc_tx
    import lp_esc_pkg::*;
#(
    parameter int              CMD_W      = 8,
    parameter int              PERIOD_W   = 8,
    parameter int              WAKE_W     = 8,
    parameter int              MIN_PERIOD = 10,
    parameter logic [CMD_W-1:0] ULPS_CODE = 8'h1E
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [CMD_W-1:0]    cmd_code,
    input  logic [PERIOD_W-1:0] period_cfg,
    input  logic [WAKE_W-1:0]   wake_cfg,
    input  logic                wake_req,
    output logic [1:0]          lane_lp,
    output logic                busy
);

    localparam int N_STEPS   = ENTRY_STEPS + 2 * CMD_W;
    localparam int STEP_W    = $clog2(N_STEPS + 1);
    localparam int TW        = (PERIOD_W > WAKE_W) ? PERIOD_W : WAKE_W;
    localparam logic [STEP_W-1:0]   LAST_STEP = STEP_W'(N_STEPS - 1);
    localparam logic [PERIOD_W-1:0] MIN_P     = PERIOD_W'(MIN_PERIOD);

    typedef struct packed {
        esc_state_e          st;
        logic [STEP_W-1:0]   step;
        logic [CMD_W-1:0]    cmd;
        logic [PERIOD_W-1:0] per;
        logic [WAKE_W-1:0]   wk;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          tmr_run;
    logic          tmr_restart;
    logic [TW-1:0] tmr_limit;
    logic          tmr_done;

    always_comb begin
        seq_d       = seq_q;
        tmr_restart = 1'b0;
        tmr_run     = (seq_q.st == ST_SEND) || (seq_q.st == ST_EXIT) ||
                      (seq_q.st == ST_WAKE);
        tmr_limit   = (seq_q.st == ST_WAKE) ? TW'(seq_q.wk) : TW'(seq_q.per);
        unique case (seq_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    seq_d.st    = ST_SEND;
                    seq_d.step  = '0;
                    seq_d.cmd   = cmd_code;
                    seq_d.per   = (period_cfg < MIN_P) ? MIN_P : period_cfg;
                    seq_d.wk    = (wake_cfg == '0) ? WAKE_W'(1) : wake_cfg;
                    tmr_restart = 1'b1;
                end
            end
            ST_SEND: begin
                if (tmr_done) begin
                    if (seq_q.step == LAST_STEP) begin
                        seq_d.st = (seq_q.cmd == ULPS_CODE) ? ST_PARK : ST_EXIT;
                    end else begin
                        seq_d.step = seq_q.step + STEP_W'(1);
                    end
                end
            end
            ST_EXIT: begin
                if (tmr_done) seq_d.st = ST_IDLE;
            end
            ST_PARK: begin
                if (wake_req) begin
                    seq_d.st    = ST_WAKE;
                    tmr_restart = 1'b1;
                end
            end
            ST_WAKE: begin
                if (tmr_done) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.per  <= MIN_P;
            seq_q.wk   <= WAKE_W'(1);
        end else begin
            seq_q <= seq_d;
        end
    end

    lp_esc_timer #(.W(TW)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .done    (tmr_done)
    );

    lp_esc_encoder #(.CMD_W(CMD_W), .STEP_W(STEP_W)) enc_i (
        .st   (seq_q.st),
        .step (seq_q.step),
        .cmd  (seq_q.cmd),
        .code (lane_lp)
    );

    assign busy = (seq_q.st != ST_IDLE);

    // R1: idle lane rests in stop state
    assert_idle_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_lp == LP_11));

    // R2: a busy lane never shows stop
    assert_busy_not_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lane_lp != LP_11));

    // R2: a sequence only starts on a command strobe
    assert_start_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R5: during the send phase the code only moves at a period boundary
    assert_code_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SEND && $past(seq_q.st) == ST_SEND && lane_lp != $past(lane_lp))
        |-> $past(tmr_done));

    // R6: parked lane holds all-low
    assert_park_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_PARK) |-> (lane_lp == LP_00 && busy));

    // R7 and R8: stop is always entered from a mark state
    assert_exit_via_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(lane_lp) == LP_10));

    // R10: wake phase is reached only from the parked state
    assert_wake_from_park_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAKE && $past(seq_q.st) != ST_WAKE) |-> ($past(seq_q.st) == ST_PARK));

endmodule

// File: tb/lp_esc_tx_tb.sv
module lp_esc_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_P      = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] period_cfg = '0;
    logic [7:0] wake_cfg = '0;
    logic       wake_req = 1'b0;
    logic [1:0] lane_lp;
    logic       busy;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_esc_tx #(.MIN_PERIOD(MIN_P)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .period_cfg (period_cfg),
        .wake_cfg   (wake_cfg),
        .wake_req   (wake_req),
        .lane_lp    (lane_lp),
        .busy       (busy)
    );

    task automatic check(input string req, input logic [1:0] code_exp, input logic busy_exp);
        n_checks++;
        if (lane_lp !== code_exp || busy !== busy_exp) begin
            n_fails++;
            $display("FAIL %s: lane=%b busy=%b, expected lane=%b busy=%b at t=%0t",
                     req, lane_lp, busy, code_exp, busy_exp, $time);
        end
    endtask

    // Expected line code for send step s, computed from R3 and R4
    function automatic logic [1:0] step_code(input int s, input logic [7:0] c);
        if (s < 4) begin
            case (s)
                0: return 2'b10;
                1: return 2'b00;
                2: return 2'b01;
                default: return 2'b00;
            endcase
        end
        if (((s - 4) % 2) == 1) return 2'b00;
        return c[7 - (s - 4) / 2] ? 2'b10 : 2'b01;
    endfunction

    task automatic run_cmd(input logic [7:0] c, input int pcfg, input int wcfg,
                           input bit poke);
        int eff;
        int weff;
        eff  = (pcfg < MIN_P) ? MIN_P : pcfg;
        weff = (wcfg == 0) ? 1 : wcfg;
        @(negedge clk);
        cmd_code   = c;
        period_cfg = 8'(pcfg);
        wake_cfg   = 8'(wcfg);
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
        // R2, R3, R4, R5: every cycle of the send phase
        for (int s = 0; s < 20; s++) begin
            for (int k = 0; k < eff; k++) begin
                check(s < 4 ? "R3" : "R4/R5", step_code(s, c), 1'b1);
                cmd_valid = 1'b0;
                wake_req  = 1'b0;
                if (poke && s == 5 && k == 0) begin
                    cmd_valid  = 1'b1;      // R9: ignored while busy
                    cmd_code   = ~c;
                    period_cfg = 8'd40;
                end
                if (poke && s == 7 && k == 1) wake_req = 1'b1;  // R10
                @(negedge clk);
            end
        end
        cmd_valid = 1'b0;
        wake_req  = 1'b0;
        if (c == 8'h1E) begin
            for (int k = 0; k < 25; k++) begin
                check("R6", 2'b00, 1'b1);
                @(negedge clk);
            end
            check("R6", 2'b00, 1'b1);
            wake_req = 1'b1;
            @(negedge clk);
            wake_req = 1'b0;
            for (int k = 0; k < weff; k++) begin
                check("R7", 2'b10, 1'b1);
                @(negedge clk);
            end
            check("R7", 2'b11, 1'b0);
        end else begin
            for (int k = 0; k < eff; k++) begin
                check("R8", 2'b10, 1'b1);
                @(negedge clk);
            end
            check("R8", 2'b11, 1'b0);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1", 2'b11, 1'b0);
        end
    endtask

    task automatic test_reset();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1", 2'b11, 1'b0);
        end
    endtask

    task automatic test_idle_wake();
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int k = 0; k < 5; k++) begin
            check("R10", 2'b11, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: cycles=%0d, expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_reset();
        run_cmd(8'h1E, 3, 5, 1'b0);   // R5 clamp, R6, R7
        run_cmd(8'hA5, 12, 0, 1'b1);  // R4, R8, R9, R10
        test_idle_wake();             // R10
        run_cmd(8'h1E, 10, 0, 1'b0);  // R7 wake of one cycle
        run_cmd(8'h81, 11, 3, 1'b0);  // R4 edge bits, R8
        finish_run();
    end

endmodule